// File: doc/BRIEF.md
# 100 Mb/s Receive Stream-Start Detector

This block sits on the serial code-bit stream of a 100 Mb/s receiver, after descrambling, and decides when a frame begins. It keeps a sliding window of the ten most recent code bits, which is two 5-bit code groups. While the line is quiet, the window shows ten ones. When activity appears, the block waits until the first zero has reached the position where a start delimiter would put it. It then compares the window with the delimiter pair 11000 10001. A match starts reception. Any other active window is treated as a false carrier.

During reception, the position of the match fixes the 5-bit group boundary. The two delimiter groups are reported as preamble nibbles 0101. Every later group is handed on, raw and 5 bits wide, to a downstream 4B5B decoder. After a false carrier, the error outputs stay up and new delimiters are ignored until the window shows ten ones again. A sticky status bit records that a false carrier occurred.

The input stream has no back-pressure. The line cannot be paused, so `bit_valid` marks the cycles that carry a code bit and there is no ready signal. Output groups are strobed by `grp_valid` for a single cycle, and the consumer must take each group in that cycle.

Top module: `sof_detector`

## Requirements
- R1: Synchronous active-high reset leaves `carrier`, `data_valid`, `rx_err`, `pre_stb`, `grp_valid` and `start_err` low, `rx_nib` at 0, and the window filled with ones.
- R2: While idle, `carrier`, `data_valid` and `rx_err` are low and `rx_nib` is 0.
- R3: From idle, the zeros of a window are said to form separate runs when at least one 1 lies between two of them. When the window's zeros first form two or more separate runs, `carrier` rises at that clock edge. Once the leading zero has advanced to window index 7 (index 0 is the newest bit), a window equal to 11000 10001 (first-received bit first) raises `data_valid` at the edge that captures the final delimiter bit.
- R4: In reception, `rx_nib` is 0101. `pre_stb` pulses at the edge that accepts the delimiter, and again at the next accepted bit, one pulse for each replaced delimiter group.
- R5: After the delimiter, every fifth accepted bit produces one `grp_valid` pulse. `grp_data` carries those five bits with the first-received bit in bit 4.
- R6: If the aligned window is not the delimiter, a false carrier is entered at that edge: `carrier` and `rx_err` are high, `data_valid` is low and `rx_nib` is 4'b1110.
- R7: `start_err` is set when a false carrier is entered and stays set until `clr_stat` is high at a clock edge. If a new false carrier arrives at the same edge, setting wins.
- R8: During a false carrier, delimiter patterns are ignored. The block returns to idle, dropping `carrier` and `rx_err`, at the edge that completes a window of ten ones.
- R9: While idle, a window whose zeros form at most one contiguous run (for example 0, 00 or 000 between ones) is ignored and `carrier` stays low.
- R10: `eof` high during reception returns the block to idle at that edge, with `carrier` and `data_valid` low, and refills the window with ones.
- R11: Cycles with `bit_valid` low neither shift the window nor advance the group count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Descrambled code bit |
| eof | input | 1 | End of frame from the downstream decoder |
| clr_stat | input | 1 | Clears the sticky false-carrier flag |
| carrier | output | 1 | Carrier sense |
| data_valid | output | 1 | Receive data valid |
| rx_err | output | 1 | Receive error (false carrier) |
| rx_nib | output | 4 | Receive nibble: 0101 in reception, 1110 on false carrier |
| pre_stb | output | 1 | Pulses once for each substituted preamble nibble |
| grp_valid | output | 1 | One-cycle strobe for `grp_data` |
| grp_data | output | 5 | Aligned code group, first-received bit in bit 4 |
| start_err | output | 1 | Sticky false-carrier flag |

## Verification
The embedded properties watch every cycle for the relations that hold regardless of the input stream:
- data valid never appears without carrier;
- a false carrier never jumps straight into reception;
- the sticky flag never drops without a clear, and is always set when an error begins;
- groups never arrive on adjacent cycles;
- the window holds still on stall cycles.

The exact cycle at which carrier and data valid rise for a particular delimiter alignment, the content and spacing of each delivered group under stalls, the benign-zero patterns, and the ten-ones release after a false carrier can only be shown by the bench's scenarios.

// File: rtl/sof_pkg.sv
package sof_pkg;
  localparam int GRP_W     = 5;
  localparam int NIB_W     = 4;
  localparam int WIN_W     = 2 * GRP_W;
  localparam int IDX_W     = $clog2(WIN_W);
  // the leading zero of the first delimiter group sits behind two ones
  localparam int ALIGN_POS = WIN_W - 3;
  localparam logic [WIN_W-1:0] PAT_JK  = 10'b11000_10001;
  localparam logic [NIB_W-1:0] NIB_PRE = 4'b0101;
  localparam logic [NIB_W-1:0] NIB_FC  = 4'b1110;

  typedef enum logic [1:0] {ST_IDLE, ST_ALIGN, ST_RECV, ST_FALSE} sof_state_e;
endpackage

// File: rtl/sof_window.sv
module sof_window
  import sof_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             flush,
  output logic [WIN_W-1:0] win_nxt,
  output logic             all_ones,
  output logic             multi_run,
  output logic [IDX_W-1:0] lead_zero
);
  logic [WIN_W-1:0] win;
  logic [WIN_W-1:0] zeros;
  logic [WIN_W-1:0] run_start;

  always_ff @(posedge clk) begin
    if (rst || flush) win <= '1;
    else              win <= win_nxt;
  end

  assign win_nxt  = bit_valid ? {win[WIN_W-2:0], bit_in} : win;
  assign zeros    = ~win_nxt;
  assign all_ones = (zeros == '0);

  // a zero run starts where a zero has a one (or the window edge) above it
  genvar gi;
  generate
    for (gi = 0; gi < WIN_W - 1; gi++) begin : g_run
      assign run_start[gi] = zeros[gi] & ~zeros[gi+1];
    end
  endgenerate
  assign run_start[WIN_W-1] = zeros[WIN_W-1];
  assign multi_run = ((run_start & (run_start - 1'b1)) != '0);

  always_comb begin
    lead_zero = '0;
    for (int i = 0; i < WIN_W; i++) begin
      if (zeros[i]) lead_zero = IDX_W'(i);
    end
  end

  AST_WIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!bit_valid && !flush) |=> $stable(win)); // R11
endmodule

// File: rtl/sof_group_align.sv
module sof_group_align
  import sof_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             active,
  input  logic             bit_valid,
  input  logic [GRP_W-1:0] grp_src,
  output logic             pre_stb,
  output logic             grp_valid,
  output logic [GRP_W-1:0] grp_data
);
  localparam int CNT_W = $clog2(GRP_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GRP_W - 1);

  logic [CNT_W-1:0] cnt;
  logic             k_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      k_pend    <= 1'b0;
      pre_stb   <= 1'b0;
      grp_valid <= 1'b0;
      grp_data  <= '0;
    end else begin
      pre_stb   <= 1'b0;
      grp_valid <= 1'b0;
      if (start) begin
        cnt     <= '0;
        k_pend  <= 1'b1;
        pre_stb <= 1'b1;
      end else if (active && bit_valid) begin
        k_pend  <= 1'b0;
        pre_stb <= k_pend;
        if (cnt == CNT_LAST) begin
          cnt       <= '0;
          grp_valid <= 1'b1;
          grp_data  <= grp_src;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (!active) begin
        k_pend <= 1'b0;
      end
    end
  end

  AST_GRP_GAP: assert property (@(posedge clk) disable iff (rst)
    grp_valid |=> !grp_valid); // R5
endmodule

// File: rtl/sof_detector.sv
module sof_detector
  import sof_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             eof,
  input  logic             clr_stat,
  output logic             carrier,
  output logic             data_valid,
  output logic             rx_err,
  output logic [NIB_W-1:0] rx_nib,
  output logic             pre_stb,
  output logic             grp_valid,
  output logic [GRP_W-1:0] grp_data,
  output logic             start_err
);
  sof_state_e       st, st_n;
  logic [IDX_W-1:0] hold, hold_n;
  logic [WIN_W-1:0] win_nxt;
  logic             all_ones, multi_run, is_jk, decide, match, fc_hit, flush;
  logic [IDX_W-1:0] lead_zero;

  assign flush = (st == ST_RECV) && eof;

  sof_window u_win (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .flush(flush), .win_nxt(win_nxt), .all_ones(all_ones),
    .multi_run(multi_run), .lead_zero(lead_zero)
  );

  assign is_jk  = (win_nxt == PAT_JK);
  assign decide = bit_valid &&
                  (((st == ST_IDLE) && multi_run && (lead_zero >= IDX_W'(ALIGN_POS))) ||
                   ((st == ST_ALIGN) && (hold == IDX_W'(1))));

  always_comb begin
    st_n   = st;
    hold_n = hold;
    match  = 1'b0;
    fc_hit = 1'b0;
    if (decide) begin
      if (is_jk) begin
        st_n  = ST_RECV;
        match = 1'b1;
      end else begin
        st_n   = ST_FALSE;
        fc_hit = 1'b1;
      end
    end else begin
      unique case (st)
        ST_IDLE:  if (bit_valid && multi_run) begin
                    st_n   = ST_ALIGN;
                    hold_n = IDX_W'(ALIGN_POS) - lead_zero;
                  end
        ST_ALIGN: if (bit_valid) hold_n = hold - 1'b1;
        ST_RECV:  if (eof) st_n = ST_IDLE;
        ST_FALSE: if (bit_valid && all_ones) st_n = ST_IDLE;
        default:  st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      hold      <= '0;
      start_err <= 1'b0;
    end else begin
      st   <= st_n;
      hold <= hold_n;
      if (fc_hit)        start_err <= 1'b1;
      else if (clr_stat) start_err <= 1'b0;
    end
  end

  assign carrier    = (st != ST_IDLE);
  assign data_valid = (st == ST_RECV);
  assign rx_err     = (st == ST_FALSE);
  always_comb begin
    unique case (st)
      ST_RECV:  rx_nib = NIB_PRE;
      ST_FALSE: rx_nib = NIB_FC;
      default:  rx_nib = '0;
    endcase
  end

  sof_group_align u_grp (
    .clk(clk), .rst(rst), .start(match), .active(st == ST_RECV),
    .bit_valid(bit_valid), .grp_src(win_nxt[GRP_W-1:0]),
    .pre_stb(pre_stb), .grp_valid(grp_valid), .grp_data(grp_data)
  );

  AST_DV_CARRIER: assert property (@(posedge clk) disable iff (rst)
    data_valid |-> carrier); // R3
  AST_DV_PREAMBLE: assert property (@(posedge clk) disable iff (rst)
    $rose(data_valid) |-> pre_stb); // R4
  AST_FC_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_err) |-> start_err); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (start_err && !clr_stat) |=> start_err); // R7
  AST_FC_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
    rx_err |=> !data_valid); // R8
  AST_EOF_DROP: assert property (@(posedge clk) disable iff (rst)
    (data_valid && eof) |=> !carrier); // R10
endmodule

// File: tb/tb_sof_detector.sv
module tb_sof_detector;
  import sof_pkg::*;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst = 1'b1, bit_valid = 1'b0, bit_in = 1'b1, eof = 1'b0, clr_stat = 1'b0;
  logic carrier, data_valid, rx_err, pre_stb, grp_valid, start_err;
  logic [NIB_W-1:0] rx_nib;
  logic [GRP_W-1:0] grp_data, mon_exp;
  logic [GRP_W-1:0] exp_q[$];
  int n_chk = 0, n_err = 0;

  always #(CLK_NS/2) clk = ~clk;

  sof_detector dut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in), .eof(eof),
    .clr_stat(clr_stat), .carrier(carrier), .data_valid(data_valid), .rx_err(rx_err),
    .rx_nib(rx_nib), .pre_stb(pre_stb), .grp_valid(grp_valid), .grp_data(grp_data),
    .start_err(start_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_NS/2);
  endtask

  task automatic send_bit(input logic b);
    bit_in = b;
    bit_valid = 1'b1;
    tick();
    bit_valid = 1'b0;
  endtask

  task automatic send_seq(input logic [9:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic ones_quiet(input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      send_bit(1'b1);
      if (carrier || rx_err || data_valid) bad++;
    end
    chk(req, bad, 0);
  endtask

  task automatic send_grp(input logic [GRP_W-1:0] g);
    exp_q.push_back(g);
    for (int i = GRP_W - 1; i >= 0; i--) send_bit(g[i]);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // scoreboard monitor: compare each delivered group with the oldest expected one
  always @(posedge clk) begin
    #1;
    if (!rst && grp_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL R5 unexpected group: actual=%0d expected=none", grp_data);
      end else begin
        mon_exp = exp_q.pop_front();
        if (grp_data !== mon_exp) begin
          n_err++;
          $display("FAIL R5 group data: actual=%0d expected=%0d", grp_data, mon_exp);
        end
      end
    end
  end

  initial begin
    #(CLK_NS * 100000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_NS/2);
    rst = 1'b0;
    // R1 reset state
    chk("R1 carrier", carrier, 0);
    chk("R1 data_valid", data_valid, 0);
    chk("R1 rx_err", rx_err, 0);
    chk("R1 rx_nib", int'(rx_nib), 0);
    chk("R1 start_err", start_err, 0);
    chk("R1 grp_valid", grp_valid, 0);

    ones_quiet(12, "R2 idle ones");
    // R9 benign zero runs
    send_bit(1'b0);
    ones_quiet(10, "R9 single zero");
    send_seq(10'b00, 2);
    ones_quiet(10, "R9 adjacent pair");
    send_seq(10'b000, 3);
    ones_quiet(10, "R9 run of three");

    // R3/R4 delimiter
    send_seq(10'b110001, 6);
    chk("R3 no carrier before second run", carrier, 0);
    send_bit(1'b0);
    chk("R3 carrier on activity", carrier, 1);
    chk("R3 not yet valid", data_valid, 0);
    send_seq(10'b001, 3);
    chk("R3 data_valid on delimiter", data_valid, 1);
    chk("R4 preamble nibble", int'(rx_nib), 5);
    chk("R4 first strobe", pre_stb, 1);
    exp_q.push_back(5'b10110);
    send_bit(1'b1);
    chk("R4 second strobe", pre_stb, 1);
    send_bit(1'b0);
    chk("R4 strobe ends", pre_stb, 0);
    send_seq(10'b110, 3);
    chk("R5 first group on fifth bit", exp_q.size(), 0);
    // R11 stall inside a group
    exp_q.push_back(5'b01101);
    send_seq(10'b01, 2);
    repeat (3) tick();
    chk("R11 group held during stall", exp_q.size(), 1);
    send_seq(10'b101, 3);
    chk("R11 group after stall", exp_q.size(), 0);
    send_grp(5'b00000);
    send_grp(5'b11111);
    chk("R5 groups drained", exp_q.size(), 0);
    eof = 1'b1;
    tick();
    eof = 1'b0;
    chk("R10 carrier dropped", carrier, 0);
    chk("R10 data_valid dropped", data_valid, 0);

    // second delimiter at another bit count
    ones_quiet(13, "R10 window refilled");
    send_seq(10'b1100010001, 10);
    chk("R3 second alignment", data_valid, 1);
    send_grp(5'b10011);
    chk("R5 second frame group", exp_q.size(), 0);
    eof = 1'b1;
    tick();
    eof = 1'b0;
    ones_quiet(12, "R2 idle again");

    // R6 false carrier
    send_seq(10'b1010, 4);
    chk("R6 carrier on activity", carrier, 1);
    send_seq(10'b1111, 4);
    chk("R6 no error before aligned window", rx_err, 0);
    send_bit(1'b1);
    chk("R6 rx_err", rx_err, 1);
    chk("R6 carrier", carrier, 1);
    chk("R6 data_valid low", data_valid, 0);
    chk("R6 nibble", int'(rx_nib), 14);
    chk("R7 flag set", start_err, 1);

    // R8 lockout
    send_seq(10'b1100010001, 10);
    chk("R8 delimiter ignored", data_valid, 0);
    chk("R8 error held", rx_err, 1);
    send_seq(10'b11111111, 8);
    chk("R8 error until ten ones", rx_err, 1);
    send_bit(1'b1);
    chk("R8 released", rx_err, 0);
    chk("R8 carrier dropped", carrier, 0);
    chk("R7 flag sticky", start_err, 1);

    clr_stat = 1'b1;
    tick();
    clr_stat = 1'b0;
    chk("R7 flag cleared", start_err, 0);

    send_seq(10'b1010, 4);
    send_seq(10'b1111, 4);
    clr_stat = 1'b1;
    send_bit(1'b1);
    clr_stat = 1'b0;
    chk("R7 set wins over clear", start_err, 1);
    send_seq(10'b1111111111, 10);
    chk("R8 released again", rx_err, 0);

    repeat (3) tick();
    finish_run();
  end
endmodule